// File: doc/BRIEF.md
# Reader Chip Startup Sequencer

This block takes an external contactless reader chip from power-on to a known working state. After power-on it waits a long settling interval and then drives the chip's active-high reset pin for a fixed hold time. After releasing the pin and a short pause, it polls the chip's command register through a generic register request port. A separate serial master serves that port.

The chip can answer with zero while it is still powered down, so a zero read on its own cannot prove the chip is ready. The sequencer therefore first waits until the low six bits of the command register read as all ones, which shows the chip's internal reset has begun. Only then does it wait for those six bits to read as all zeros. Next it writes zero to the page register, which turns paging off, and reads the command register once more to confirm that the bus interface works.

Every delay is a microsecond value multiplied by a clock-frequency parameter, so a test can use short values. Both polling phases have their own limit on the number of reads. The block ends with a done flag and a 2-bit status. A start pulse, when the block is done, runs the whole sequence again.

Top module: `chip_boot_seq`

## Requirements
- R1: After reset release, or after an accepted start, `chip_rst` stays low for POR_US*CLK_MHZ clock cycles and then stays high for RST_US*CLK_MHZ cycles; any product of zero counts as one cycle.
- R2: After `chip_rst` falls, `reg_req` stays low for REL_US*CLK_MHZ cycles; the next request is a read (`reg_we`=0) of CMD_ADDR, and `reg_req` is never high while `chip_rst` is high.
- R3: `reg_req` rises for one transaction at a time and, together with `reg_we`, `reg_addr` and `reg_wdata`, stays unchanged until a cycle with `reg_ack` high, in which the block takes `reg_rdata`.
- R4: In the first phase the command register is read repeatedly. The phase ends only on a read whose bits [5:0] equal 6'h3F, whatever bits [7:6] hold; zero reads do not end it. Between consecutive reads `reg_req` stays low for POLL_GAP cycles.
- R5: In the second phase, which starts only after R4 is met, the command register is read every POLL_GAP cycles until bits [5:0] equal zero, whatever bits [7:6] hold.
- R6: After the second phase the block writes 8'h00 to PAGE_ADDR and then reads CMD_ADDR once. It finishes with status 2'd0 (ok) if the whole byte read is 8'h00, and 2'd1 (interface error) otherwise.
- R7: If a phase makes MAX_POLLS reads without success, the block stops with no further transactions. The status is 2'd2 when the first phase fails and 2'd3 when the second phase fails.
- R8: `busy` is high while the sequence runs and `done` is high once it has finished; the two are never high together, and `status` holds its value while `done` stays high.
- R9: A `start` pulse while `busy` is high has no effect. A `start` pulse while `done` is high restarts the sequence from the power-on wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, acts as power-on |
| start | input | 1 | Restart request, accepted only when done |
| chip_rst | output | 1 | Active-high reset / power-down pin of the reader chip |
| reg_req | output | 1 | Register transaction request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | AW | Register address |
| reg_wdata | output | DW | Write data |
| reg_ack | input | 1 | Transaction completion, qualifies reg_rdata |
| reg_rdata | input | DW | Read data |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence finished |
| status | output | 2 | 0 ok, 1 interface error, 2 phase-one timeout, 3 phase-two timeout |

## Verification
The assertions check several rules on every cycle. A request stays stable until acknowledged. No request is made while the reset pin is high. A timed state is left only when its timer reaches zero. No page write happens unless the all-ones pattern has been seen. The poll counter never passes its limit. Busy and done always disagree, and the status holds while the block is done. Other properties depend on chosen read values and latencies, so only the bench scenarios can show them: the exact reset widths, the release pause, the poll gap, the masking of the top bits, the rejection of early zero reads, and which of the four outcomes results from a given reply sequence.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_IFERR = 2'd1,
    ST_TMO1  = 2'd2,
    ST_TMO2  = 2'd3
  } boot_status_e;

  typedef enum logic [3:0] {
    S_POR,
    S_RST,
    S_REL,
    S_P1_RD,
    S_P1_GAP,
    S_P2_RD,
    S_P2_GAP,
    S_PG_WR,
    S_CHK_RD,
    S_DONE
  } boot_state_e;

  // low six bits all ones: internal reset recognised
  function automatic logic cmd_reset_seen(input logic [7:0] v);
    return v[5:0] == 6'h3F;
  endfunction

  // low six bits all zero: internal reset finished
  function automatic logic cmd_idle(input logic [7:0] v);
    return v[5:0] == 6'h00;
  endfunction

  function automatic int unsigned us_to_cycles(input int unsigned us,
                                               input int unsigned mhz);
    int unsigned c;
    c = us * mhz;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic is_bus_state(input boot_state_e s);
    return (s == S_P1_RD) || (s == S_P2_RD) || (s == S_PG_WR) || (s == S_CHK_RD);
  endfunction

endpackage

// File: rtl/boot_timer.sv
module boot_timer #(
  parameter int unsigned CW   = 8,
  parameter int unsigned INIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= CW'(INIT);
    else if (load)      cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/boot_tally.sv
module boot_tally #(
  parameter int unsigned PW  = 4,
  parameter int unsigned MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  logic [PW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '0;
    else if (clr) count_q <= '0;
    else if (inc) count_q <= count_q + 1'b1;
  end

  // the read now completing is the MAX-th of its phase
  assign last = (count_q == PW'(MAX - 1));

  assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= PW'(MAX));

endmodule

// File: rtl/boot_bus_if.sv
module boot_bus_if #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic          xfer_done,
  output logic          reg_req,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic          reg_ack
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_req   <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else if (go) begin
      reg_req   <= 1'b1;
      reg_we    <= go_we;
      reg_addr  <= go_addr;
      reg_wdata <= go_wdata;
    end else if (reg_ack) begin
      reg_req   <= 1'b0;
    end
  end

  assign xfer_done = reg_req & reg_ack;

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_addr)
                               && $stable(reg_wdata)));

  assert_one_txn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (!reg_req || reg_ack));

endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import boot_pkg::*;
#(
  parameter int unsigned CW        = 8,
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 8,
  parameter int unsigned POR_CYC   = 1,
  parameter int unsigned RST_CYC   = 1,
  parameter int unsigned REL_CYC   = 1,
  parameter int unsigned POLL_GAP  = 1,
  parameter logic [AW-1:0] PAGE_ADDR = '0,
  parameter logic [AW-1:0] CMD_ADDR  = AW'(1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          poll_clr,
  output logic          poll_inc,
  input  logic          poll_last,
  output logic          bus_go,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_done,
  input  logic [DW-1:0] bus_rdata,
  output logic          chip_rst,
  output logic          busy,
  output logic          done,
  output logic [1:0]    status
);
  boot_state_e  state_q, state_d;
  boot_status_e status_q, status_d;
  logic         seen_busy_q;

  // named internal events
  logic ev_reset_seen, ev_idle_seen, ev_restart;
  assign ev_reset_seen = (state_q == S_P1_RD) && bus_done && cmd_reset_seen(bus_rdata[7:0]);
  assign ev_idle_seen  = (state_q == S_P2_RD) && bus_done && cmd_idle(bus_rdata[7:0]);
  assign ev_restart    = (state_q == S_DONE) && start;

  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    case (state_q)
      S_POR: if (tmr_zero) begin
        state_d = S_RST; tmr_load = 1'b1; tmr_val = CW'(RST_CYC - 1);
      end
      S_RST: if (tmr_zero) begin
        state_d = S_REL; tmr_load = 1'b1; tmr_val = CW'(REL_CYC - 1);
      end
      S_REL: if (tmr_zero) begin
        state_d = S_P1_RD; poll_clr = 1'b1;
      end
      S_P1_RD: if (bus_done) begin
        poll_inc = 1'b1;
        if (ev_reset_seen) begin
          state_d = S_P2_GAP; poll_clr = 1'b1;
          tmr_load = 1'b1; tmr_val = CW'(POLL_GAP - 1);
        end else if (poll_last) begin
          state_d = S_DONE; status_d = ST_TMO1;
        end else begin
          state_d = S_P1_GAP; tmr_load = 1'b1; tmr_val = CW'(POLL_GAP - 1);
        end
      end
      S_P1_GAP: if (tmr_zero) state_d = S_P1_RD;
      S_P2_RD: if (bus_done) begin
        poll_inc = 1'b1;
        if (ev_idle_seen) begin
          state_d = S_PG_WR;
        end else if (poll_last) begin
          state_d = S_DONE; status_d = ST_TMO2;
        end else begin
          state_d = S_P2_GAP; tmr_load = 1'b1; tmr_val = CW'(POLL_GAP - 1);
        end
      end
      S_P2_GAP: if (tmr_zero) state_d = S_P2_RD;
      S_PG_WR:  if (bus_done) state_d = S_CHK_RD;
      S_CHK_RD: if (bus_done) begin
        state_d  = S_DONE;
        status_d = (bus_rdata == '0) ? ST_OK : ST_IFERR;
      end
      S_DONE: if (ev_restart) begin
        state_d = S_POR; status_d = ST_OK;
        tmr_load = 1'b1; tmr_val = CW'(POR_CYC - 1);
      end
      default: state_d = S_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_POR;
      status_q    <= ST_OK;
      seen_busy_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
      if (ev_restart)         seen_busy_q <= 1'b0;
      else if (ev_reset_seen) seen_busy_q <= 1'b1;
    end
  end

  assign bus_go    = is_bus_state(state_d) && (state_d != state_q);
  assign bus_we    = (state_d == S_PG_WR);
  assign bus_addr  = (state_d == S_PG_WR) ? PAGE_ADDR : CMD_ADDR;
  assign bus_wdata = '0;

  assign chip_rst = (state_q == S_RST);
  assign done     = (state_q == S_DONE);
  assign busy     = (state_q != S_DONE);
  assign status   = status_q;

  assert_hold_timed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RST && !tmr_zero) |=> (state_q == S_RST));

  assert_busy_before_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_go && bus_we) |-> seen_busy_q);

  assert_done_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done != busy);

  assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(status));

endmodule

// File: rtl/chip_boot_seq.sv
module chip_boot_seq
  import boot_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 10,
  parameter int unsigned POR_US    = 500000,
  parameter int unsigned RST_US    = 100000,
  parameter int unsigned REL_US    = 100,
  parameter int unsigned POLL_GAP  = 20,
  parameter int unsigned MAX_POLLS = 1000,
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 8,
  parameter logic [AW-1:0] PAGE_ADDR = AW'(0),
  parameter logic [AW-1:0] CMD_ADDR  = AW'(1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          chip_rst,
  output logic          reg_req,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic          reg_ack,
  input  logic [DW-1:0] reg_rdata,
  output logic          busy,
  output logic          done,
  output logic [1:0]    status
);
  localparam int unsigned POR_CYC = us_to_cycles(POR_US, CLK_MHZ);
  localparam int unsigned RST_CYC = us_to_cycles(RST_US, CLK_MHZ);
  localparam int unsigned REL_CYC = us_to_cycles(REL_US, CLK_MHZ);
  localparam int unsigned GAP_CYC = (POLL_GAP == 0) ? 1 : POLL_GAP;
  localparam int unsigned TMAX    = max2(max2(POR_CYC, RST_CYC), max2(REL_CYC, GAP_CYC));
  localparam int unsigned CW      = $clog2(TMAX + 1);
  localparam int unsigned PW      = $clog2(MAX_POLLS + 1);

  logic          tmr_zero, tmr_load;
  logic [CW-1:0] tmr_val;
  logic          poll_clr, poll_inc, poll_last;
  logic          bus_go, bus_we, bus_done;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;

  boot_timer #(.CW(CW), .INIT(POR_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  boot_tally #(.PW(PW), .MAX(MAX_POLLS)) u_tally (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc), .last(poll_last)
  );

  boot_bus_if #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .go(bus_go), .go_we(bus_we), .go_addr(bus_addr),
    .go_wdata(bus_wdata), .xfer_done(bus_done), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack)
  );

  boot_ctrl #(
    .CW(CW), .AW(AW), .DW(DW), .POR_CYC(POR_CYC), .RST_CYC(RST_CYC),
    .REL_CYC(REL_CYC), .POLL_GAP(GAP_CYC), .PAGE_ADDR(PAGE_ADDR), .CMD_ADDR(CMD_ADDR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .poll_clr(poll_clr), .poll_inc(poll_inc), .poll_last(poll_last),
    .bus_go(bus_go), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .bus_rdata(reg_rdata),
    .chip_rst(chip_rst), .busy(busy), .done(done), .status(status)
  );

  assert_no_access_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |-> !reg_req);

endmodule

// File: tb/chip_boot_seq_test.sv
module chip_boot_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ = 1, POR = 12, RST = 7, REL = 4, GAP = 3, MAXP = 6;
  localparam logic [7:0] CMDA = 8'h01, PAGEA = 8'h00;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic chip_rst, reg_req, reg_we, reg_ack = 1'b0, busy, done;
  logic [7:0] reg_addr, reg_wdata, reg_rdata = 8'h00;
  logic [1:0] status;

  chip_boot_seq #(
    .CLK_MHZ(MHZ), .POR_US(POR), .RST_US(RST), .REL_US(REL),
    .POLL_GAP(GAP), .MAX_POLLS(MAXP), .PAGE_ADDR(PAGEA), .CMD_ADDR(CMDA)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chip_rst(chip_rst),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata), .busy(busy), .done(done), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  logic [7:0] resp [16];
  int lat = 0;

  // observations, cleared by arm()
  int ph, por_cnt, rst_cnt, rel_cnt, rises, cmd_reads, writes, bad_addr;
  int gap_run, first_gap, wcnt;
  logic [7:0] waddr, wdat;
  logic prev_rst, prev_req;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arm();
    ph = 0; por_cnt = 0; rst_cnt = 0; rel_cnt = 0; rises = 0; cmd_reads = 0;
    writes = 0; bad_addr = 0; gap_run = 0; first_gap = -1; wcnt = 0;
    waddr = 8'hAA; wdat = 8'hAA; prev_rst = 1'b0; prev_req = 1'b0;
  endtask

  // monitor and register responder, all at falling edges
  initial begin
    arm();
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (chip_rst && !prev_rst) rises++;
        case (ph)
          0: if (chip_rst) begin ph = 1; rst_cnt = 1; end else por_cnt++;
          1: if (chip_rst) rst_cnt++;
             else if (reg_req) ph = 3;
             else begin ph = 2; rel_cnt = 1; end
          2: if (reg_req) ph = 3; else rel_cnt++;
          default: begin
            if (!reg_req && writes == 0) gap_run++;
            if (reg_req && !prev_req) begin
              if (first_gap < 0 && cmd_reads >= 1) first_gap = gap_run;
              gap_run = 0;
            end
          end
        endcase
        prev_rst = chip_rst;
        prev_req = reg_req;
        if (reg_ack) reg_ack = 1'b0;
        else if (reg_req) begin
          if (wcnt >= lat) begin
            wcnt = 0;
            reg_ack = 1'b1;
            if (reg_we) begin
              writes++; waddr = reg_addr; wdat = reg_wdata;
            end else if (reg_addr == CMDA) begin
              reg_rdata = resp[(cmd_reads > 15) ? 15 : cmd_reads];
              cmd_reads++;
            end else bad_addr++;
          end else wcnt++;
        end
      end
    end
  end

  task automatic fill(input int id);
    logic [7:0] s [8];
    case (id)
      0: s = '{8'h00, 8'h00, 8'h00, 8'hFF, 8'h3F, 8'h12, 8'h00, 8'h00};
      1: s = '{8'h00, 8'h7F, 8'h80, 8'h40, 8'h40, 8'h40, 8'h40, 8'h40};
      2: s = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      3: s = '{8'h3F, 8'h3F, 8'h3F, 8'h3F, 8'h3F, 8'h3F, 8'h3F, 8'h3F};
      default: s = '{8'h01, 8'h3E, 8'h3F, 8'h3F, 8'hC0, 8'h00, 8'h00, 8'h00};
    endcase
    for (int i = 0; i < 16; i++) resp[i] = s[(i > 7) ? 7 : i];
  endtask

  // independent outcome model: status, reads expected, write expected
  task automatic model(output int est, output int erd, output int ewr);
    int i = 0;
    bit ok = 0;
    ewr = 0;
    for (int p = 0; p < MAXP && !ok; p++) begin
      if ((resp[i] & 8'h3F) == 8'h3F) ok = 1;
      i++;
    end
    if (!ok) begin est = 2; erd = i; return; end
    ok = 0;
    for (int p = 0; p < MAXP && !ok; p++) begin
      if ((resp[i] & 8'h3F) == 8'h00) ok = 1;
      i++;
    end
    if (!ok) begin est = 3; erd = i; return; end
    ewr = 1;
    est = (resp[i] == 8'h00) ? 0 : 1;
    erd = i + 1;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    if (!done) chk(0, "R8 sequence never finished", 0, 1);
  endtask

  task automatic run(input int id, input int l, input bit power_on, input bit poke);
    int est, erd, ewr;
    fill(id);
    lat = l;
    model(est, erd, ewr);
    @(negedge clk);
    arm();
    if (power_on) begin
      #1 rst_n = 1'b1;
    end else begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    if (poke) begin
      while (!chip_rst) @(negedge clk);
      start = 1'b1;               // R9: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    wait_done();
    @(negedge clk);
    chk(por_cnt == POR, "R1 power-on wait", por_cnt, POR);
    chk(rst_cnt == RST, "R1 reset hold", rst_cnt, RST);
    chk(rel_cnt == REL, "R2 release pause", rel_cnt, REL);
    chk(rises == 1, "R9 single reset pulse", rises, 1);
    chk(bad_addr == 0, "R2 read address", bad_addr, 0);
    chk(cmd_reads == erd, "R4 R5 command reads", cmd_reads, erd);
    if (erd >= 2) chk(first_gap == GAP, "R4 poll gap", first_gap, GAP);
    chk(writes == ewr, "R6 page write count", writes, ewr);
    if (ewr == 1) chk(waddr == PAGEA && wdat == 8'h00, "R6 page write value",
                      int'({waddr, wdat}), int'({PAGEA, 8'h00}));
    if (est >= 2) chk(int'(status) == est, "R7 timeout code", status, est);
    else          chk(int'(status) == est, "R6 result code", status, est);
    chk(done && !busy, "R8 done flags", {done, busy}, 2);
    repeat (3) @(negedge clk);
    chk(int'(status) == est && done, "R8 status held", status, est);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!chip_rst && !reg_req && !done && busy, "R8 reset state",
        {chip_rst, reg_req, done, busy}, 1);
    run(0, 0, 1'b1, 1'b0);
    for (int id = 0; id < 5; id++)
      for (int l = 0; l < 3; l++)
        run(id, l, 1'b0, 1'b0);
    run(0, 1, 1'b0, 1'b1);
    run(3, 2, 1'b0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule